// File: doc/BRIEF.md
# MDIO Management Master

This block is the station-management engine of an Ethernet MAC. It lets software read and write registers inside an external PHY over the two-wire management interface: a clock (MDC) that the block generates, and a bidirectional data line (MDIO) that both ends share. Software works through two 16-bit registers on a simple register bus.

To write a PHY register, software first loads the data register with the value. It then writes the command register with the PHY address, the register number, the direction, a clock-range code and the busy bit set. To read, it writes only the command register, with the direction bit clear. The block divides the system clock down to MDC according to the clock-range code. It then shifts out a clause-22 frame: preamble, start, opcode, addresses, turnaround and 16 data bits. On a read it releases the line for the turnaround and data phases and captures the PHY's reply.

When the last bit has gone, busy clears by itself, and for a read the data register then holds the returned value. While busy is set, software writes to either register have no effect. This protects the frame that is in flight.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the command register (offset 0x10) and the data register (offset 0x14) both read 0x0000, MDC is low and the MDIO output enable is low.
- R2: The command register reads back the fields as they were written: bit 0 busy, bit 1 direction (1 = write), bits [4:2] clock-range code, bits [10:6] register number, bits [15:11] PHY address, with bit 5 always reading 0. The data register reads back its 16-bit value. Any other offset reads 0.
- R3: A command-register write with bit 0 set starts a transfer. Busy then reads 1 for exactly 64 × (divide ratio) clock cycles and afterwards reads 0. A write with bit 0 clear only stores the fields and produces no MDC edges.
- R4: One MDC period lasts the divide ratio selected by the code: 0→42, 1→62, 2→16, 3→26, 4→102, 5→124, and 6 or 7→124 system clocks. Each transfer has exactly 64 MDC rising edges, and MDC is low whenever busy is 0.
- R5: A write transfer drives all 64 bits with the output enable high. Sampled at MDC rising edges, MSB first, the bits are: 32 ones, 01, opcode 01, PHY address, register number, turnaround 10, then the data register value.
- R6: A read transfer drives 32 ones, 01, opcode 10, PHY address and register number (the first 46 bits). The output enable is low during the remaining 18 bits (turnaround and data).
- R7: On a read, MDIO is sampled at each MDC rising edge of bits 48 to 63, MSB first. That value is in the data register once busy reads 0.
- R8: While busy is 1, writes to the command register and to the data register are ignored. The fields, the frame being sent and the data register keep their values, and no second transfer starts.
- R9: Between transfers the output enable is low and MDIO out is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte offset for reads and writes |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value for the pad driver |
| mdioOe | output | 1 | MDIO pad output enable |
| mdioIn | input | 1 | MDIO value from the pad |

## Verification
Faults in the bit counter or the divider show up on the busy bit. Busy stays high either too long or too short, so a wrong count is seen at the end of the transfer, within one MDC period. A frame shifter that slips or a wrong opcode corrupts the bit stream seen at the very next MDC rising edge after the fault. A bad output-enable decision shows at bit 46 of a read. A capture register that shifts on the wrong edge produces a wrong value in the data register as soon as busy clears. If a register accepts a write while busy, the command readback changes on the next cycle, or the frame and the data register are wrong when the transfer ends.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS       = 64;
  localparam int PREAMBLE_BITS    = 32;
  localparam int DRIVEN_READ_BITS = 46;
  localparam int DATA_BITS        = 16;
  localparam int PHY_AW           = 5;
  localparam int REG_AW           = 5;
  localparam int SEL_W            = 3;

  // Control to datapath strobes
  typedef struct packed {
    logic load;   // capture header and start the divider
    logic run;    // transfer in progress
    logic drive;  // MDIO pad enable for the current bit
  } mdioStrobe_t;

  // Frame header as written in the start cycle
  typedef struct packed {
    logic              isWrite;
    logic [SEL_W-1:0]  clkSel;
    logic [PHY_AW-1:0] phyAddr;
    logic [REG_AW-1:0] regNum;
  } mdioHdr_t;

  // Half of the MDC divide ratio for a clock-range code
  function automatic logic [6:0] halfPeriod(input logic [SEL_W-1:0] code);
    case (code)
      3'd0:    halfPeriod = 7'd21;  // ratio 42
      3'd1:    halfPeriod = 7'd31;  // ratio 62
      3'd2:    halfPeriod = 7'd8;   // ratio 16
      3'd3:    halfPeriod = 7'd13;  // ratio 26
      3'd4:    halfPeriod = 7'd51;  // ratio 102
      default: halfPeriod = 7'd62;  // ratio 124
    endcase
  endfunction

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int                 ADDR_W      = 8,
  parameter int                 BUS_W       = 16,
  parameter logic [ADDR_W-1:0]  CMD_OFFSET  = 8'h10,
  parameter logic [ADDR_W-1:0]  DATA_OFFSET = 8'h14
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [BUS_W-1:0]     regWrData,
  input  logic                 fall,
  input  logic [DATA_BITS-1:0] capData,
  output mdioStrobe_t          strobe,
  output mdioHdr_t             hdr,
  output logic [BUS_W-1:0]     cmdView,
  output logic [BUS_W-1:0]     dataView
);

  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] READ_DRIVE = CNT_W'(DRIVEN_READ_BITS);

  logic                  busyQ;
  logic                  writeQ;
  logic [SEL_W-1:0]      selQ;
  logic [REG_AW-1:0]     regNumQ;
  logic [PHY_AW-1:0]     phyQ;
  logic [DATA_BITS-1:0]  dataQ;
  logic [CNT_W-1:0]      bitQ;
  logic                  cmdWr;
  logic                  dataWr;

  assign cmdWr  = regWrEn && (regAddr == CMD_OFFSET)  && !busyQ;
  assign dataWr = regWrEn && (regAddr == DATA_OFFSET) && !busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      writeQ  <= 1'b0;
      selQ    <= '0;
      regNumQ <= '0;
      phyQ    <= '0;
      dataQ   <= '0;
      bitQ    <= '0;
    end else begin
      if (cmdWr) begin
        busyQ   <= regWrData[0];
        writeQ  <= regWrData[1];
        selQ    <= regWrData[4:2];
        regNumQ <= regWrData[10:6];
        phyQ    <= regWrData[15:11];
        bitQ    <= '0;
      end else if (busyQ && fall) begin
        bitQ <= bitQ + 1'b1;
        if (bitQ == LAST_BIT) begin
          busyQ <= 1'b0;
          if (!writeQ) dataQ <= capData;
        end
      end
      if (dataWr) dataQ <= regWrData[DATA_BITS-1:0];
    end
  end

  always_comb begin
    strobe.load  = cmdWr && regWrData[0];
    strobe.run   = busyQ;
    strobe.drive = busyQ && (writeQ || (bitQ < READ_DRIVE));
  end

  always_comb begin
    hdr.isWrite = regWrData[1];
    hdr.clkSel  = regWrData[4:2];
    hdr.regNum  = regWrData[10:6];
    hdr.phyAddr = regWrData[15:11];
  end

  assign cmdView  = BUS_W'({phyQ, regNumQ, 1'b0, selQ, writeQ, busyQ});
  assign dataView = BUS_W'(dataQ);

endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mdioStrobe_t          strobe,
  input  mdioHdr_t             hdr,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 mdioIn,
  output logic                 mdc,
  output logic                 mdioOut,
  output logic                 mdioOe,
  output logic                 fall,
  output logic [DATA_BITS-1:0] capData
);

  localparam logic [PREAMBLE_BITS-1:0] PREAMBLE = {PREAMBLE_BITS{1'b1}};

  logic [DIV_W-1:0]      halfQ;
  logic [DIV_W-1:0]      divQ;
  logic                  mdcQ;
  logic [FRAME_BITS-1:0] shiftQ;
  logic [DATA_BITS-1:0]  capQ;
  logic                  toggle;
  logic                  rise;
  logic [FRAME_BITS-1:0] frame;

  assign toggle = strobe.run && (divQ == halfQ - 1'b1);
  assign rise   = toggle && !mdcQ;
  assign fall   = toggle &&  mdcQ;

  always_comb begin
    frame = {PREAMBLE, 2'b01,
             hdr.isWrite ? 2'b01 : 2'b10,
             hdr.phyAddr, hdr.regNum,
             hdr.isWrite ? 2'b10 : 2'b00,
             hdr.isWrite ? wrData : {DATA_BITS{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfQ  <= '0;
      divQ   <= '0;
      mdcQ   <= 1'b0;
      shiftQ <= '0;
      capQ   <= '0;
    end else begin
      if (strobe.load) begin
        halfQ  <= DIV_W'(halfPeriod(hdr.clkSel));
        divQ   <= '0;
        mdcQ   <= 1'b0;
        shiftQ <= frame;
      end else if (strobe.run) begin
        if (toggle) begin
          divQ <= '0;
          mdcQ <= !mdcQ;
        end else begin
          divQ <= divQ + 1'b1;
        end
        if (fall) shiftQ <= shiftQ << 1;
        if (rise) capQ   <= {capQ[DATA_BITS-2:0], mdioIn};
      end else begin
        divQ <= '0;
        mdcQ <= 1'b0;
      end
    end
  end

  assign mdc     = mdcQ;
  assign mdioOut = strobe.run ? shiftQ[FRAME_BITS-1] : 1'b1;
  assign mdioOe  = strobe.drive;
  assign capData = capQ;

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                BUS_W       = 16,
  parameter logic [ADDR_W-1:0] CMD_OFFSET  = 8'h10,
  parameter logic [ADDR_W-1:0] DATA_OFFSET = 8'h14,
  parameter int                DIV_W       = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  mdioStrobe_t          strobe;
  mdioHdr_t             hdr;
  logic                 fall;
  logic [DATA_BITS-1:0] capData;
  logic [BUS_W-1:0]     cmdView;
  logic [BUS_W-1:0]     dataView;

  mdio_ctrl #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W),
    .CMD_OFFSET(CMD_OFFSET), .DATA_OFFSET(DATA_OFFSET)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .fall(fall), .capData(capData),
    .strobe(strobe), .hdr(hdr),
    .cmdView(cmdView), .dataView(dataView)
  );

  mdio_datapath #(.DIV_W(DIV_W)) i_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .hdr(hdr),
    .wrData(dataView[DATA_BITS-1:0]),
    .mdioIn(mdioIn),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .fall(fall), .capData(capData)
  );

  always_comb begin
    if (regAddr == CMD_OFFSET)       regRdData = cmdView;
    else if (regAddr == DATA_OFFSET) regRdData = dataView;
    else                             regRdData = '0;
  end

endmodule

// File: rtl/mdio_checker.sv
module mdio_checker #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             mdc,
  input logic             mdioOut,
  input logic             mdioOe,
  input logic [BUS_W-1:0] cmdView
);

  logic busy;
  assign busy = cmdView[0];

  // R9: pad released and line idle high between transfers
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdioOe && mdioOut));

  // R4: no MDC activity while idle
  a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  // R6: the enable comes up only at the start of a transfer
  a_r6_oe_only_at_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe) |-> $rose(busy));

  // R3: busy clears together with the final MDC falling edge
  a_r3_end_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $fell(mdc));

  // R8: command fields frozen while a transfer runs
  a_r8_fields_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cmdView));

endmodule

bind mdio_mgmt_master mdio_checker #(.BUS_W(BUS_W)) i_mdio_checker (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOut(mdioOut),
  .mdioOe(mdioOe), .cmdView(cmdView)
);

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;

  typedef struct packed {
    logic [2:0]  sel;
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] val;
    logic [7:0]  ratio;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{3'd0, 1'b1, 5'h01, 5'h00, 16'hA5C3, 8'd42},
    '{3'd2, 1'b0, 5'h1F, 5'h01, 16'h1234, 8'd16},
    '{3'd3, 1'b1, 5'h10, 5'h1F, 16'hFFFF, 8'd26},
    '{3'd1, 1'b0, 5'h00, 5'h02, 16'h8001, 8'd62},
    '{3'd4, 1'b1, 5'h0A, 5'h15, 16'h0000, 8'd102},
    '{3'd5, 1'b0, 5'h15, 5'h0A, 16'h7E81, 8'd124},
    '{3'd7, 1'b0, 5'h03, 5'h04, 16'hC35A, 8'd124}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = 16'h0000;
  logic [15:0] regRdData;
  logic        mdc;
  logic        mdioOut;
  logic        mdioOe;
  logic        mdioIn = 1'b1;

  int nChecks = 0;
  int nFail = 0;

  // monitor / PHY model state
  int          cycCnt = 0;
  int          riseCnt = 0;
  int          fallCnt = 0;
  int          rise1 = 0;
  int          rise2 = 0;
  logic        mdcPrev = 1'b0;
  logic [63:0] frameCap = '0;
  logic [63:0] oeCap = '0;
  logic        phyRd = 1'b0;
  logic [15:0] phyVal = '0;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    cycCnt = cycCnt + 1;
    if (mdc && !mdcPrev) begin
      riseCnt = riseCnt + 1;
      frameCap = {frameCap[62:0], mdioOut};
      oeCap = {oeCap[62:0], mdioOe};
      if (riseCnt == 1) rise1 = cycCnt;
      if (riseCnt == 2) rise2 = cycCnt;
    end
    if (!mdc && mdcPrev) begin
      fallCnt = fallCnt + 1;
      if (phyRd && fallCnt >= 48 && fallCnt <= 63) mdioIn = phyVal[63 - fallCnt];
      else if (phyRd && fallCnt == 47)             mdioIn = 1'b0;
      else                                         mdioIn = 1'b1;
    end
    mdcPrev = mdc;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic clearMon();
    riseCnt = 0; fallCnt = 0; frameCap = '0; oeCap = '0; rise1 = 0; rise2 = 0;
  endtask

  // counts negedges with busy high, starting right after the start write
  task automatic waitIdle(output int n);
    logic [15:0] r;
    n = 0;
    regRead(8'h10, r);
    while (r[0] && n < 20000) begin
      n++;
      @(negedge clk);
      regRead(8'h10, r);
    end
  endtask

  task automatic runVec(input vec_t v);
    logic [63:0] expFrame;
    logic [15:0] r;
    int n;
    expFrame = {32'hFFFF_FFFF, 2'b01, v.wr ? 2'b01 : 2'b10, v.phy, v.rg,
                v.wr ? 2'b10 : 2'b00, v.wr ? v.val : 16'h0000};
    if (v.wr) regWrite(8'h14, v.val);
    phyRd = !v.wr; phyVal = v.val;
    clearMon();
    regWrite(8'h10, {v.phy, v.rg, 1'b0, v.sel, v.wr, 1'b1});
    waitIdle(n);
    check(n == 64 * int'(v.ratio), "R3 busy duration", 64'(n), 64'(64 * int'(v.ratio)));
    check(rise2 - rise1 == int'(v.ratio), "R4 MDC period", 64'(rise2 - rise1), 64'(v.ratio));
    check(riseCnt == 64, "R4 MDC rising edge count", 64'(riseCnt), 64'd64);
    if (v.wr) begin
      check(frameCap == expFrame, "R5 write frame", frameCap, expFrame);
      check(oeCap == {64{1'b1}}, "R5 write enable", oeCap, {64{1'b1}});
      regRead(8'h14, r);
      check(r == v.val, "R5 data register kept", 64'(r), 64'(v.val));
    end else begin
      check(frameCap[63:18] == expFrame[63:18], "R6 read header", 64'(frameCap[63:18]), 64'(expFrame[63:18]));
      check(oeCap == {{46{1'b1}}, 18'h0}, "R6 read enable release", oeCap, {{46{1'b1}}, 18'h0});
      regRead(8'h14, r);
      check(r == v.val, "R7 read data captured", 64'(r), 64'(v.val));
    end
    #1;
    check(!mdioOe && mdioOut, "R9 idle after transfer", {62'h0, mdioOe, mdioOut}, 64'h1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic [15:0] r;
    logic [15:0] cmd;
    int n;
    int savedRises;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(8'h10, r);
    check(r == 16'h0, "R1 command reset", 64'(r), 64'h0);
    regRead(8'h14, r);
    check(r == 16'h0, "R1 data reset", 64'(r), 64'h0);
    check(!mdc && !mdioOe, "R1 pins reset", {62'h0, mdc, mdioOe}, 64'h0);
    check(mdioOut, "R9 idle line high", 64'(mdioOut), 64'h1);

    // vector table
    for (int i = 0; i < NVEC; i++) runVec(VECS[i]);

    // R2 / R3: field store without start, reserved bit reads 0
    clearMon();
    cmd = {5'h13, 5'h0C, 1'b0, 3'd5, 1'b1, 1'b0};
    regWrite(8'h10, cmd | 16'h0020);
    regRead(8'h10, r);
    check(r == cmd, "R2 command readback", 64'(r), 64'(cmd));
    repeat (300) @(negedge clk);
    check(riseCnt == 0, "R3 no transfer without busy", 64'(riseCnt), 64'h0);
    regWrite(8'h14, 16'h5AA5);
    regRead(8'h14, r);
    check(r == 16'h5AA5, "R2 data readback", 64'(r), 64'h5AA5);
    regRead(8'h18, r);
    check(r == 16'h0, "R2 unmapped offset", 64'(r), 64'h0);

    // R8: writes while busy
    regWrite(8'h14, 16'h1357);
    phyRd = 1'b0;
    clearMon();
    cmd = {5'h02, 5'h03, 1'b0, 3'd2, 1'b1, 1'b1};
    regWrite(8'h10, cmd);
    repeat (100) @(negedge clk);
    regWrite(8'h14, 16'hFFFF);
    regWrite(8'h10, 16'hFFFF);
    regRead(8'h10, r);
    check(r == cmd, "R8 command ignored while busy", 64'(r), 64'(cmd));
    regRead(8'h14, r);
    check(r == 16'h1357, "R8 data ignored while busy", 64'(r), 64'h1357);
    waitIdle(n);
    check(frameCap[15:0] == 16'h1357, "R8 frame data intact", 64'(frameCap[15:0]), 64'h1357);
    regRead(8'h14, r);
    check(r == 16'h1357, "R8 data after transfer", 64'(r), 64'h1357);
    savedRises = riseCnt;
    repeat (200) @(negedge clk);
    check(riseCnt == savedRises && savedRises == 64, "R8 no second transfer", 64'(riseCnt), 64'd64);
    regRead(8'h10, r);
    check(r[0] == 1'b0, "R3 busy cleared", 64'(r[0]), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule